// File: doc/BRIEF.md
# Interlaced video sync timing generator

This block produces the reference timing for an interlaced standard-definition video stream. From a pixel-rate clock enable it runs a sample counter within each line and a line counter within each frame, and from those positions it derives a horizontal strobe, a vertical strobe, a field flag and an active-video qualifier. Both counters are brought out so that downstream pixel logic can address its data by position.

A parameter selects one of four systems: 525-line or 625-line, each with rectangular or square pixels. The samples per line, the active samples per line and the per-field active line ranges follow the usual values for the chosen system. The vertical strobe ends in a different part of the line for each field, so that a receiver can recover the field by sampling the horizontal strobe when the vertical strobe falls: high means the odd field follows, low the even field.

Top module: `vst_sync_gen`

## Requirements
- R1: The sample count `h_cnt_o` advances by one on each cycle with `pix_en_i` high and wraps from H_TOTAL-1 to 0; by default H_TOTAL is 858 (525 rectangular), 864 (625 rectangular), 780 (525 square) and 944 (625 square), and STD values 0, 1, 2, 3 select these systems in that order.
- R2: The line count `v_cnt_o` runs from 1 to 525 (525-line) or 625 (625-line), advances only when the sample count wraps, and wraps from the last line to 1.
- R3: `href_o` is high exactly while `h_cnt_o` is below H_ACTIVE, on every line; by default H_ACTIVE is 720, 720, 640 and 768 for STD 0 to 3.
- R4: `vactive_o` is high only when `href_o` is high and the line is active: lines 21..263 and 283..525 for STD 0, lines 23..262 and 286..525 for STD 2, lines 23..310 and 336..623 for STD 1 and 3.
- R5: `field_o` is 1 on lines 1..3 and 266..525 for the 525-line systems, and on lines 313..625 for the 625-line systems; 0 elsewhere.
- R6: `vref_o` is high for exactly 3 lines' worth of samples starting at a field start position: line 1 (525) or 624 (625) at sample H_ACTIVE/2 for the odd-field window, and line 264 (STD 0), 263 (STD 2) or 311 (625) at sample H_ACTIVE+(H_TOTAL-H_ACTIVE)/2 for the even-field window; `vref_o` and `vactive_o` are never high together.
- R7: At every falling edge of `vref_o`, `href_o` is high when `field_o` is 0 (odd field) and low when `field_o` is 1 (even field).
- R8: While `rst_ni` is low, `h_cnt_o` is 0 and `v_cnt_o` is 1, and the other outputs take the values R3 to R6 give for that position.
- R9: With `pix_en_i` low, both counts and all strobes hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pix_en_i | input | 1 | Pixel-rate clock enable |
| h_cnt_o | output | 10 | Sample position within the line |
| v_cnt_o | output | 10 | Line number within the frame, from 1 |
| href_o | output | 1 | Horizontal strobe, high over active samples |
| vref_o | output | 1 | Vertical strobe |
| vactive_o | output | 1 | Active-video qualifier |
| field_o | output | 1 | Field flag, 1 for the even field |

## Verification
A sample counter that skips or double-steps shows at once on `h_cnt_o` and, within one line, as a wrong-length `href_o` high time and a late or early line advance. A wrong line count or table entry shows as `vactive_o`, `field_o` or `vref_o` toggling on the wrong line, visible by the end of the affected field; a vertical window edge placed in the wrong half of the line shows at the next `vref_o` fall as a horizontal strobe level that contradicts the field flag. Shortened lines with the standard line tables let whole frames of every system be observed, while default-count instances confirm the real line lengths.

// File: rtl/vst_pkg.sv
package vst_pkg;
  typedef enum logic [1:0] {
    STD_525_RECT = 2'd0,
    STD_625_RECT = 2'd1,
    STD_525_SQ   = 2'd2,
    STD_625_SQ   = 2'd3
  } std_e;

  localparam int HCW = 10;
  localparam int VCW = 10;

  typedef struct packed {
    logic [15:0] act1_lo;
    logic [15:0] act1_hi;
    logic [15:0] act2_lo;
    logic [15:0] act2_hi;
    logic [15:0] fld_head;     // last line of the leading field=1 run, 0 if none
    logic [15:0] fld_even_lo;  // first line of the trailing field=1 run
    logic [15:0] vr_odd;
    logic [15:0] vr_even;
  } line_tbl_t;

  function automatic int h_total_f(std_e s);
    case (s)
      STD_525_RECT: return 858;
      STD_625_RECT: return 864;
      STD_525_SQ:   return 780;
      default:      return 944;
    endcase
  endfunction

  function automatic int h_active_f(std_e s);
    case (s)
      STD_525_RECT: return 720;
      STD_625_RECT: return 720;
      STD_525_SQ:   return 640;
      default:      return 768;
    endcase
  endfunction

  function automatic int v_total_f(std_e s);
    return (s == STD_625_RECT || s == STD_625_SQ) ? 625 : 525;
  endfunction

  function automatic line_tbl_t line_tbl_f(std_e s);
    line_tbl_t t;
    case (s)
      STD_525_RECT: t = '{16'd21, 16'd263, 16'd283, 16'd525, 16'd3, 16'd266, 16'd1, 16'd264};
      STD_525_SQ:   t = '{16'd23, 16'd262, 16'd286, 16'd525, 16'd3, 16'd266, 16'd1, 16'd263};
      default:      t = '{16'd23, 16'd310, 16'd336, 16'd623, 16'd0, 16'd313, 16'd624, 16'd311};
    endcase
    return t;
  endfunction
endpackage

// File: rtl/vst_hcount.sv
module vst_hcount import vst_pkg::*; #(
  parameter int H_TOTAL = 858
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  output logic [HCW-1:0] h_o,
  output logic           wrap_o
);
  localparam logic [HCW-1:0] H_LAST = HCW'(H_TOTAL - 1);

  logic [HCW-1:0] h_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   h_q <= '0;
    else if (en_i) h_q <= (h_q == H_LAST) ? '0 : h_q + 1'b1;
  end

  assign h_o    = h_q;
  assign wrap_o = en_i && (h_q == H_LAST);

  assert_h_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_q <= H_LAST);
  assert_h_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (h_q != H_LAST) |=> h_q == $past(h_q) + 1'b1);
  assert_h_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(h_q));
endmodule

// File: rtl/vst_vcount.sv
module vst_vcount import vst_pkg::*; #(
  parameter int V_TOTAL = 525
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           adv_i,
  output logic [VCW-1:0] v_o
);
  localparam logic [VCW-1:0] V_LAST = VCW'(V_TOTAL);
  localparam logic [VCW-1:0] V_FIRST = VCW'(1);

  logic [VCW-1:0] v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    v_q <= V_FIRST;
    else if (adv_i) v_q <= (v_q == V_LAST) ? V_FIRST : v_q + 1'b1;
  end

  assign v_o = v_q;

  assert_v_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q >= V_FIRST) && (v_q <= V_LAST));
  assert_v_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(v_q));
endmodule

// File: rtl/vst_line_decode.sv
module vst_line_decode import vst_pkg::*; #(
  parameter std_e STD        = STD_525_RECT,
  parameter int   H_TOTAL    = 858,
  parameter int   H_ACTIVE   = 720,
  parameter int   VREF_LINES = 3
) (
  input  logic [HCW-1:0] h_i,
  input  logic [VCW-1:0] v_i,
  output logic           href_o,
  output logic           vactive_o,
  output logic           field_o,
  output logic           vref_o
);
  localparam int        V_T = v_total_f(STD);
  localparam line_tbl_t TBL = line_tbl_f(STD);

  int hv, vv;
  logic line_act;
  logic [1:0] win;

  always_comb begin
    hv = int'(h_i);
    vv = int'(v_i);
    line_act = ((vv >= int'(TBL.act1_lo)) && (vv <= int'(TBL.act1_hi))) ||
               ((vv >= int'(TBL.act2_lo)) && (vv <= int'(TBL.act2_hi)));
    field_o  = (vv <= int'(TBL.fld_head)) || (vv >= int'(TBL.fld_even_lo));
    href_o   = hv < H_ACTIVE;
    vactive_o = href_o && line_act;
  end

  // k=0: window ending mid active region (odd), k=1: ending in blanking (even)
  for (genvar k = 0; k < 2; k++) begin : g_win
    localparam int ST   = (k == 0) ? int'(TBL.vr_odd) : int'(TBL.vr_even);
    localparam int EDGE = (k == 0) ? H_ACTIVE / 2 : H_ACTIVE + (H_TOTAL - H_ACTIVE) / 2;
    int d;
    always_comb begin
      d = (vv >= ST) ? vv - ST : vv + V_T - ST;
      win[k] = ((d == 0) && (hv >= EDGE)) ||
               ((d > 0) && (d < VREF_LINES)) ||
               ((d == VREF_LINES) && (hv < EDGE));
    end
  end

  assign vref_o = |win;
endmodule

// File: rtl/vst_sync_gen.sv
module vst_sync_gen import vst_pkg::*; #(
  parameter std_e STD        = STD_525_RECT,
  parameter int   H_TOTAL    = h_total_f(STD),
  parameter int   H_ACTIVE   = h_active_f(STD),
  parameter int   VREF_LINES = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pix_en_i,
  output logic [HCW-1:0] h_cnt_o,
  output logic [VCW-1:0] v_cnt_o,
  output logic           href_o,
  output logic           vref_o,
  output logic           vactive_o,
  output logic           field_o
);
  localparam int V_TOTAL = v_total_f(STD);

  logic h_wrap;

  vst_hcount #(.H_TOTAL(H_TOTAL)) u_hcount (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (pix_en_i),
    .h_o    (h_cnt_o),
    .wrap_o (h_wrap)
  );

  vst_vcount #(.V_TOTAL(V_TOTAL)) u_vcount (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (h_wrap),
    .v_o    (v_cnt_o)
  );

  vst_line_decode #(
    .STD(STD), .H_TOTAL(H_TOTAL), .H_ACTIVE(H_ACTIVE), .VREF_LINES(VREF_LINES)
  ) u_decode (
    .h_i       (h_cnt_o),
    .v_i       (v_cnt_o),
    .href_o    (href_o),
    .vactive_o (vactive_o),
    .field_o   (field_o),
    .vref_o    (vref_o)
  );

  assert_act_in_href_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vactive_o |-> href_o);
  assert_vref_blank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vref_o |-> !vactive_o);
  assert_field_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vref_o) |-> (href_o == !field_o));
  assert_href_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(href_o) |-> (h_cnt_o == '0));
endmodule

// File: tb/tb_vst_sync_gen.sv
module tb_vst_sync_gen;
  import vst_pkg::*;

  localparam int N = 5;
  localparam int STDI[N] = '{0, 3, 0, 1, 2};
  localparam int HT[N]   = '{858, 944, 40, 40, 40};
  localparam int HA[N]   = '{720, 768, 24, 24, 24};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_en = 1'b0;
  always #10 clk = ~clk;

  logic [HCW-1:0] h_o [N];
  logic [VCW-1:0] v_o [N];
  logic href [N], vref [N], vact [N], fld [N];

  for (genvar gi = 0; gi < N; gi++) begin : g_dut
    if (gi < 2) begin : g_def
      vst_sync_gen #(.STD(std_e'(STDI[gi]))) dut (
        .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pix_en),
        .h_cnt_o(h_o[gi]), .v_cnt_o(v_o[gi]), .href_o(href[gi]),
        .vref_o(vref[gi]), .vactive_o(vact[gi]), .field_o(fld[gi]));
    end else begin : g_short
      vst_sync_gen #(.STD(std_e'(STDI[gi])), .H_TOTAL(HT[gi]), .H_ACTIVE(HA[gi])) dut (
        .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pix_en),
        .h_cnt_o(h_o[gi]), .v_cnt_o(v_o[gi]), .href_o(href[gi]),
        .vref_o(vref[gi]), .vactive_o(vact[gi]), .field_o(fld[gi]));
    end
  end

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic check(bit ok, string req, int idx, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s inst%0d t=%0t: actual %0d expected %0d", req, idx, $time, act, exp);
    end
  endtask

  function automatic int vtot(int s);
    return (s == 1 || s == 3) ? 625 : 525;
  endfunction

  function automatic bit exp_line_act(int s, int v);
    case (s)
      0:       return (v >= 21 && v <= 263) || (v >= 283 && v <= 525);
      2:       return (v >= 23 && v <= 262) || (v >= 286 && v <= 525);
      default: return (v >= 23 && v <= 310) || (v >= 336 && v <= 623);
    endcase
  endfunction

  function automatic bit exp_field(int s, int v);
    if (s == 1 || s == 3) return v >= 313;
    return (v <= 3) || (v >= 266);
  endfunction

  // window on the linear sample position within the frame
  function automatic bit in_span(int s, int ht, int v, int h, int line0, int smp0);
    int total = vtot(s) * ht;
    int pos   = (v - 1) * ht + h;
    int p0    = (line0 - 1) * ht + smp0;
    int off   = ((pos - p0) % total + total) % total;
    return off < 3 * ht;
  endfunction

  function automatic bit exp_vref(int s, int ht, int ha, int v, int h);
    int odd_l  = (s == 1 || s == 3) ? 624 : 1;
    int even_l = (s == 0) ? 264 : (s == 2) ? 263 : 311;
    return in_span(s, ht, v, h, odd_l, ha / 2) ||
           in_span(s, ht, v, h, even_l, ha + (ht - ha) / 2);
  endfunction

  // reference position
  int mh [N];
  int mv [N];
  always @(posedge clk or negedge rst_n) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        mh[i] = 0; mv[i] = 1;
      end else if (pix_en) begin
        if (mh[i] == HT[i] - 1) begin
          mh[i] = 0;
          mv[i] = (mv[i] == vtot(STDI[i])) ? 1 : mv[i] + 1;
        end else begin
          mh[i] = mh[i] + 1;
        end
      end
    end
  end

  task automatic check_pos(int i, string tag);
    check(int'(h_o[i]) == mh[i], {tag, "/R1 h_cnt"}, i, int'(h_o[i]), mh[i]);
    check(int'(v_o[i]) == mv[i], {tag, "/R2 v_cnt"}, i, int'(v_o[i]), mv[i]);
    check(href[i] == (mh[i] < HA[i]), {tag, "/R3 href"}, i, href[i], mh[i] < HA[i]);
    check(vact[i] == ((mh[i] < HA[i]) && exp_line_act(STDI[i], mv[i])), {tag, "/R4 vactive"},
          i, vact[i], (mh[i] < HA[i]) && exp_line_act(STDI[i], mv[i]));
    check(fld[i] == exp_field(STDI[i], mv[i]), {tag, "/R5 field"}, i, fld[i],
          exp_field(STDI[i], mv[i]));
    check(vref[i] == exp_vref(STDI[i], HT[i], HA[i], mv[i], mh[i]), {tag, "/R6 vref"}, i,
          vref[i], exp_vref(STDI[i], HT[i], HA[i], mv[i], mh[i]));
  endtask

  logic prev_vref [N];
  int   falls [N];
  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rst_n && !done) begin
        check_pos(i, "run");
        if (prev_vref[i] && !vref[i]) begin
          falls[i]++;
          check(href[i] == !fld[i], "R7 href at vref fall", i, href[i], !fld[i]);
        end
      end
      prev_vref[i] = vref[i];
    end
  end

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic reset_phase;
    @(negedge clk); #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) begin
      check(int'(h_o[i]) == 0, "R8 reset h", i, int'(h_o[i]), 0);
      check(int'(v_o[i]) == 1, "R8 reset v", i, int'(v_o[i]), 1);
      check(fld[i] == exp_field(STDI[i], 1), "R8 reset field", i, fld[i], exp_field(STDI[i], 1));
      check(vref[i] == exp_vref(STDI[i], HT[i], HA[i], 1, 0), "R8 reset vref", i, vref[i],
            exp_vref(STDI[i], HT[i], HA[i], 1, 0));
      check(href[i] == 1'b1 && vact[i] == 1'b0, "R8 reset href/vactive", i,
            {href[i], vact[i]}, 2);
    end
    #2 rst_n = 1'b1;
  endtask

  int sh [N];
  int sv [N];
  logic sr [N];

  initial begin
    void'($urandom(32'h5eed_0421));
    for (int i = 0; i < N; i++) begin prev_vref[i] = 1'b0; falls[i] = 0; end
    reset_phase();
    // random enable pattern, a few lines at full rate first
    repeat (2000) begin @(negedge clk); pix_en = 1'b1; end
    repeat (75000) begin @(negedge clk); pix_en = ($urandom % 4) != 0; end
    // stall: nothing may move (R9)
    @(negedge clk); pix_en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin sh[i] = int'(h_o[i]); sv[i] = int'(v_o[i]); sr[i] = vref[i]; end
    repeat (50) @(negedge clk);
    for (int i = 0; i < N; i++) begin
      check(int'(h_o[i]) == sh[i], "R9 hold h", i, int'(h_o[i]), sh[i]);
      check(int'(v_o[i]) == sv[i], "R9 hold v", i, int'(v_o[i]), sv[i]);
      check(vref[i] == sr[i], "R9 hold vref", i, vref[i], sr[i]);
    end
    repeat (20000) begin @(negedge clk); pix_en = 1'b1; end
    // every short instance must have crossed several field boundaries
    for (int i = 2; i < N; i++)
      check(falls[i] >= 4, "R7 vref falls seen", i, falls[i], 4);
    // mid-run reset
    reset_phase();
    repeat (2000) begin @(negedge clk); pix_en = ($urandom % 2) != 0; end
    @(negedge clk);
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end
endmodule